// File: doc/BRIEF.md
# OSD Window Start Position Timer

This block tells an on-screen-display engine where its window begins on the video raster. It runs entirely on the display dot clock. It takes the raw horizontal and vertical sync inputs, synchronizes them and applies a software-selected active polarity to each. It then produces a horizontal-start pulse on the dot where the window's first column begins and a vertical-start flag that is high on the window's lines.

Horizontal placement is level based. A dot counter runs only while horizontal sync is at its active level and is held at zero otherwise. The window begins at dot 4·H+5, where H is a 6-bit horizontal position value. Vertical placement counts sync lines from the end of vertical sync, and the window begins at line 4·V, where V is a 6-bit vertical position value. Both position values are sampled only when a vertical sync begins, so a window never moves in the middle of a field. The running dot and line counts are exported for the rendering logic that follows.

Top module: `osd_start_timer`

## Requirements
- R1: Each sync input passes through two dot-clock flip-flops before any use. A level change on a raw sync pin acts on the counters at the second rising clock edge after it is sampled.
- R2: The dot count is zero while the synchronized horizontal sync is inactive. It rises by one on each dot clock while the sync is active, and it saturates at 511.
- R3: The horizontal start output is a one-cycle pulse. It is high while horizontal sync is active and the dot count equals 4·H+5, so it appears 4·H+7 clocks after the raw pin goes active. A line whose active time is no longer than 4·H+5 clocks produces no pulse.
- R4: The line count is zero while the synchronized vertical sync is active. Outside vertical sync it rises by one on every inactive-to-active transition of horizontal sync, and it saturates at 1023.
- R5: The vertical start flag is low during vertical sync. Outside vertical sync it is high whenever the line count is at least 4·V. With V = 0 it is high on every line after vertical sync.
- R6: Polarity select 1 makes a sync input active high, and select 0 makes it active low. Horizontal and vertical polarity are independent.
- R7: H and V are taken from the position inputs only on the inactive-to-active transition of vertical sync. Changes at other times do not affect the start outputs until the next vertical sync.
- R8: After reset the dot and line counts are zero, the horizontal start is low, the stored H and V are zero (so the vertical flag is high), and the synchronizer stages hold the inactive level of the selected polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_raw | input | 1 | Raw horizontal sync pin |
| vsync_raw | input | 1 | Raw vertical sync pin |
| hsync_pol | input | 1 | Horizontal sync polarity: 1 active high, 0 active low |
| vsync_pol | input | 1 | Vertical sync polarity: 1 active high, 0 active low |
| hpos | input | 6 | Horizontal window position H |
| vpos | input | 6 | Vertical window position V |
| h_start | output | 1 | One-cycle pulse at dot 4·H+5 |
| v_start | output | 1 | High on lines at or beyond 4·V until vertical sync |
| h_count | output | 9 | Current dot count within active horizontal sync |
| v_count | output | 10 | Current line count since vertical sync |

## Verification
Lines are driven with active times both longer and shorter than the start offset. This separates a correct compare from one that is off by a dot or that ignores the sync level. The synchronizer latency shows up in the measured pulse offset. Fields with several vertical positions, including zero and a line run past 1023, show whether the flag begins on the right line, holds, and clears with sync. Position values changed in the middle of a field, together with a swap of both polarities and the largest horizontal value, show that the stored positions move only at vertical sync and that the active level, not an edge, governs counting.

// File: rtl/osd_pos_pkg.sv
// Shared sizing for the OSD start position timer.
// Assumes the counters are wide enough to hold the largest start offset.
package osd_pos_pkg;
    localparam int POS_W       = 6;   // width of each position value
    localparam int HCNT_W      = 9;   // dot counter width
    localparam int VCNT_W      = 10;  // line counter width
    localparam int SYNC_STAGES = 2;   // synchronizer depth
    localparam int H_BIAS      = 5;   // fixed horizontal offset in dots
endpackage

// File: rtl/osd_sync_in.sv
// Brings one raw sync pin into the dot-clock domain, applies the
// selected polarity and flags the inactive-to-active transition.
// Assumes STAGES >= 1; at reset the chain is loaded with the inactive level.
module osd_sync_in #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol,
    output logic active,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last_active;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= ~pol;
                else        chain <= raw;
            end
        end else begin : g_multi
            // Shift the raw pin through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{~pol}};
                else        chain <= {chain[STAGES-2:0], raw};
            end
        end
    endgenerate

    // Level is active when the synchronized value matches the polarity.
    assign active = (chain[STAGES-1] == pol);

    // Remember the previous active level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_active <= 1'b0;
        else        last_active <= active;
    end

    assign rise = active & ~last_active;
endmodule

// File: rtl/osd_pos_latch.sv
// Holds the horizontal and vertical position values and turns them into
// dot and line targets. Values are taken only when capture is high.
// Assumes HCNT_W >= POS_W+3 and VCNT_W >= POS_W+2.
module osd_pos_latch #(
    parameter int POS_W  = 6,
    parameter int HCNT_W = 9,
    parameter int VCNT_W = 10,
    parameter int H_BIAS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [POS_W-1:0]  hpos_in,
    input  logic [POS_W-1:0]  vpos_in,
    output logic [HCNT_W-1:0] h_target,
    output logic [VCNT_W-1:0] v_target
);
    localparam int HPAD = HCNT_W - POS_W - 2;
    localparam int VPAD = VCNT_W - POS_W - 2;

    logic [POS_W-1:0] h_held;
    logic [POS_W-1:0] v_held;

    // Capture both positions together at the start of vertical sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_held <= '0;
            v_held <= '0;
        end else if (capture) begin
            h_held <= hpos_in;
            v_held <= vpos_in;
        end
    end

    // Four dots per horizontal step plus the fixed bias.
    assign h_target = {{HPAD{1'b0}}, h_held, 2'b00} + HCNT_W'(H_BIAS);
    // Four lines per vertical step.
    assign v_target = {{VPAD{1'b0}}, v_held, 2'b00};
endmodule

// File: rtl/osd_hcounter.sv
// Dot counter gated by the horizontal sync level, and the start compare.
// Assumes target never equals the saturation value.
module osd_hcounter #(
    parameter int HCNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [HCNT_W-1:0] target,
    output logic [HCNT_W-1:0] count,
    output logic              start
);
    localparam logic [HCNT_W-1:0] CMAX = '1;
    localparam logic [HCNT_W-1:0] CONE = HCNT_W'(1);

    // Count dots during active sync, hold zero otherwise, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)             count <= '0;
        else if (!active)       count <= '0;
        else if (count != CMAX) count <= count + CONE;
    end

    // Pulse on the single dot where the count meets the target.
    assign start = active && (count == target);
endmodule

// File: rtl/osd_vcounter.sv
// Line counter cleared by vertical sync and stepped by each horizontal
// sync edge, plus the window flag. Assumes line_edge is one cycle wide.
module osd_vcounter #(
    parameter int VCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              line_edge,
    input  logic [VCNT_W-1:0] target,
    output logic [VCNT_W-1:0] count,
    output logic              flag
);
    localparam logic [VCNT_W-1:0] CMAX = '1;
    localparam logic [VCNT_W-1:0] CONE = VCNT_W'(1);

    // Hold zero through vertical sync, step once per line, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                       count <= '0;
        else if (clear)                   count <= '0;
        else if (line_edge && count != CMAX) count <= count + CONE;
    end

    // Flag is high from the target line onward, outside vertical sync.
    assign flag = !clear && (count >= target);
endmodule

// File: rtl/osd_start_timer.sv
// Top of the OSD start position timer. Synchronizes both sync inputs,
// stores the positions at vertical sync and derives the start outputs.
// Assumes all inputs except the sync pins are static relative to clk.
module osd_start_timer
    import osd_pos_pkg::*;
#(
    parameter int P_POS_W  = POS_W,
    parameter int P_HCNT_W = HCNT_W,
    parameter int P_VCNT_W = VCNT_W,
    parameter int P_STAGES = SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hsync_raw,
    input  logic                vsync_raw,
    input  logic                hsync_pol,
    input  logic                vsync_pol,
    input  logic [P_POS_W-1:0]  hpos,
    input  logic [P_POS_W-1:0]  vpos,
    output logic                h_start,
    output logic                v_start,
    output logic [P_HCNT_W-1:0] h_count,
    output logic [P_VCNT_W-1:0] v_count
);
    logic                hs_act;
    logic                hs_rise;
    logic                vs_act;
    logic                vs_rise;
    logic [P_HCNT_W-1:0] h_target;
    logic [P_VCNT_W-1:0] v_target;

    osd_sync_in #(.STAGES(P_STAGES)) u_hsync (
        .clk(clk), .rst_n(rst_n), .raw(hsync_raw), .pol(hsync_pol),
        .active(hs_act), .rise(hs_rise)
    );

    osd_sync_in #(.STAGES(P_STAGES)) u_vsync (
        .clk(clk), .rst_n(rst_n), .raw(vsync_raw), .pol(vsync_pol),
        .active(vs_act), .rise(vs_rise)
    );

    osd_pos_latch #(
        .POS_W(P_POS_W), .HCNT_W(P_HCNT_W), .VCNT_W(P_VCNT_W), .H_BIAS(H_BIAS)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .capture(vs_rise),
        .hpos_in(hpos), .vpos_in(vpos),
        .h_target(h_target), .v_target(v_target)
    );

    osd_hcounter #(.HCNT_W(P_HCNT_W)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .active(hs_act), .target(h_target),
        .count(h_count), .start(h_start)
    );

    osd_vcounter #(.VCNT_W(P_VCNT_W)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .clear(vs_act), .line_edge(hs_rise),
        .target(v_target), .count(v_count), .flag(v_start)
    );
endmodule

// File: rtl/osd_start_timer_chk.sv
// Property checker for the OSD start position timer, bound to the top.
module osd_start_timer_chk #(
    parameter int HCNT_W = 9,
    parameter int VCNT_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hs_act,
    input logic              vs_act,
    input logic              vs_rise,
    input logic              h_start,
    input logic              v_start,
    input logic [HCNT_W-1:0] h_count,
    input logic [VCNT_W-1:0] v_count,
    input logic [HCNT_W-1:0] h_target,
    input logic [VCNT_W-1:0] v_target
);
    localparam logic [HCNT_W-1:0] HMAX = '1;

    // R3
    hstart_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_start |=> !h_start);
    // R3
    hstart_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_start |-> (h_count == h_target));
    // R2
    hcount_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_act |=> (h_count == '0));
    // R2
    hcount_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_act && h_count != HMAX) |=> (h_count == $past(h_count) + HCNT_W'(1)));
    // R4
    vcount_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_act |=> (v_count == '0));
    // R5
    vflag_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_act |-> !v_start);
    // R7
    target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise |=> ($stable(h_target) && $stable(v_target)));
endmodule

bind osd_start_timer osd_start_timer_chk #(.HCNT_W(P_HCNT_W), .VCNT_W(P_VCNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hs_act(hs_act), .vs_act(vs_act), .vs_rise(vs_rise),
    .h_start(h_start), .v_start(v_start), .h_count(h_count), .v_count(v_count),
    .h_target(h_target), .v_target(v_target)
);

// File: tb/osd_start_timer_test.sv
module osd_start_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_raw = 1'b0, vsync_raw = 1'b0;
    logic       hsync_pol = 1'b1, vsync_pol = 1'b1;
    logic [5:0] hpos = '0, vpos = '0;
    logic       h_start, v_start;
    logic [8:0] h_count;
    logic [9:0] v_count;

    int total = 0, bad = 0;
    int exp_h = 0, exp_v = 0;       // positions the bench expects to be held
    int since_hs = 0, hs_seen = 0, hs_at = -1;

    // reference model state
    bit hq[$];
    bit vq[$];
    int mhc = 0, mvc = 0, mhl = 0, mvl = 0;
    bit mhp = 0, mvp = 0, model_on = 0;

    osd_start_timer uut (
        .clk(clk), .rst_n(rst_n), .hsync_raw(hsync_raw), .vsync_raw(vsync_raw),
        .hsync_pol(hsync_pol), .vsync_pol(vsync_pol), .hpos(hpos), .vpos(vpos),
        .h_start(h_start), .v_start(v_start), .h_count(h_count), .v_count(v_count)
    );

    always #10 clk = ~clk;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        since_hs++;
        if (!rst_n) begin
            hq = '{~hsync_pol, ~hsync_pol};
            vq = '{~vsync_pol, ~vsync_pol};
            mhc = 0; mvc = 0; mhl = 0; mvl = 0; mhp = 0; mvp = 0;
            model_on = 1;
        end else begin
            bit ha, va;
            ha = (hq[0] == hsync_pol);
            va = (vq[0] == vsync_pol);
            mhc = ha ? ((mhc < 511) ? mhc + 1 : 511) : 0;
            if (va) mvc = 0;
            else if (ha && !mhp) mvc = (mvc < 1023) ? mvc + 1 : 1023;
            if (va && !mvp) begin mhl = hpos; mvl = vpos; end
            mhp = ha; mvp = va;
            hq.push_back(hsync_raw); void'(hq.pop_front());
            vq.push_back(vsync_raw); void'(vq.pop_front());
        end
    end

    // compare against the model every cycle, away from the rising edge
    always @(negedge clk) begin
        if (model_on) begin
            bit ha, va, eh, ev;
            ha = (hq[0] == hsync_pol);
            va = (vq[0] == vsync_pol);
            eh = ha && (mhc == 4 * mhl + 5);
            ev = !va && (mvc >= 4 * mvl);
            chk(h_count == 9'(mhc), "R2", "model h_count", int'(h_count), mhc);
            chk(v_count == 10'(mvc), "R4", "model v_count", int'(v_count), mvc);
            chk(h_start == eh, "R3", "model h_start", int'(h_start), int'(eh));
            chk(v_start == ev, "R5", "model v_start", int'(v_start), int'(ev));
        end
        if (h_start) begin hs_seen++; hs_at = since_hs; end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // one line: active for act_len clocks, then inactive for gap clocks
    task automatic line(int act_len, int gap);
        int t;
        t = 4 * exp_h + 5;
        step(1);
        hsync_raw = hsync_pol; since_hs = 0; hs_seen = 0; hs_at = -1;
        step(act_len);
        hsync_raw = ~hsync_pol;
        step(gap);
        if (act_len > t) begin
            chk(hs_seen == 1, "R3", "pulses per line", hs_seen, 1);
            // R1: two synchronizer flops add two clocks to the offset
            chk(hs_at == t + 2, "R1", "start offset", hs_at, t + 2);
        end else begin
            chk(hs_seen == 0, "R3", "pulses on short line", hs_seen, 0);
        end
    endtask

    task automatic vsync_pulse(int len);
        step(1);
        vsync_raw = vsync_pol;
        step(len);
        exp_h = hpos; exp_v = vpos;
        vsync_raw = ~vsync_pol;
        step(4);
    endtask

    initial begin
        #3_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(5);
        // R8: reset state
        chk(h_count == 0 && v_count == 0, "R8", "reset counts", int'(h_count) + int'(v_count), 0);
        chk(h_start == 0, "R8", "reset h_start", int'(h_start), 0);
        chk(v_start == 1, "R8", "reset v_start", int'(v_start), 1);
        rst_n = 1'b1;
        step(3);

        // R7: new positions not used before vertical sync
        hpos = 6'd3; vpos = 6'd2;
        line(40, 6);

        vsync_pulse(4);
        for (int k = 1; k <= 10; k++) begin
            line(30, 6);
            chk(v_count == 10'(k), "R4", "lines after vsync", int'(v_count), k);
            chk(v_start == (k >= 4 * exp_v), "R5", "window flag", int'(v_start), int'(k >= 4 * exp_v));
        end

        // R7: mid-field change keeps the old offset
        hpos = 6'd10; vpos = 6'd0;
        line(30, 6);
        chk(v_start == 1, "R7", "flag unchanged mid-field", int'(v_start), 1);

        // R3: line ending before the start dot
        line(10, 6);

        // R4/R5: hsync during vsync leaves lines at zero and flag low
        step(1);
        vsync_raw = vsync_pol;
        step(4);
        line(6, 4);
        chk(v_count == 0, "R4", "lines held in vsync", int'(v_count), 0);
        chk(v_start == 0, "R5", "flag low in vsync", int'(v_start), 0);
        exp_h = hpos; exp_v = vpos;
        vsync_raw = ~vsync_pol;
        step(4);
        chk(v_start == 1, "R5", "flag with zero position", int'(v_start), 1);
        line(60, 6);

        // R6: both polarities active low, largest horizontal position
        hsync_pol = 1'b0; hsync_raw = 1'b1;
        vsync_pol = 1'b0; vsync_raw = 1'b1;
        step(4);
        chk(h_count == 0, "R6", "idle under low polarity", int'(h_count), 0);
        hpos = 6'd63; vpos = 6'd1;
        vsync_pulse(4);
        for (int k = 1; k <= 5; k++) begin
            line(270, 6);
            chk(v_start == (k >= 4), "R6", "flag under low polarity", int'(v_start), int'(k >= 4));
        end

        // R2: dot count saturates
        step(1);
        hsync_raw = hsync_pol;
        step(600);
        chk(h_count == 9'd511, "R2", "dot saturation", int'(h_count), 511);
        hsync_raw = ~hsync_pol;
        step(4);
        chk(h_count == 0, "R2", "dot clear", int'(h_count), 0);

        // R4: line count saturates
        for (int k = 0; k < 1030; k++) begin
            hsync_raw = hsync_pol; step(2);
            hsync_raw = ~hsync_pol; step(2);
        end
        step(4);
        chk(v_count == 10'd1023, "R4", "line saturation", int'(v_count), 1023);

        step(5);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule